// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block decides which of up to sixteen bus masters owns the address bus. Priority comes from a table of sixteen level slots; each slot names a master by index, and slot 0 is the strongest level. When a master's request wins, its one-hot grant stays put until that master marks the start of its transfer. When nobody listed in the table is requesting, the grant rests on a parked master chosen by a mode field. This saves an arbitration cycle when that master is the next to use the bus.

A second output grants the data bus. It is timed against the transfer-start strobe. In fast mode the data grant can appear in the same cycle as the strobe. In delayed mode it appears at least one cycle later. Either way it waits while the data bus is reported busy. The table and the mode bits are loaded through a plain write port.

Top module: `prio_park_arbiter`

## Requirements
- R1: After reset, slot n holds master n, the parked master is 2, delay mode is off, and with no request the grant output is the one-hot vector 16'h0004.
- R2: At an arbitration point, the grant goes to the master named in the lowest-numbered slot whose master is requesting. A master named in several slots competes at its best slot. A master named in no slot is never granted.
- R3: A write with `wr_sel_i` = 0 loads slots 0–7 and `wr_sel_i` = 1 loads slots 8–15. Slot 8·sel+k takes `wr_data_i[31-4k:28-4k]`. With `wr_sel_i` = 2, bit 5 is the delay mode and bits 3:0 are the parked master. All other bits are ignored, and so are writes with `wr_sel_i` = 3.
- R4: At an arbitration point with no listed master requesting, the grant moves to the parked master, and no tenure is held.
- R5: A grant won by a requester is held unchanged until `ts_i` is seen. Table and mode writes during that time do not alter it.
- R6: Exactly one grant bit is high in every cycle.
- R7: With delay mode off, `dbg_o` is high in the cycle of `ts_i` if `dbb_i` is low. Otherwise it is high in the first later cycle with `dbb_i` low.
- R8: With delay mode on, `dbg_o` is never high in the cycle of `ts_i`. It rises in the first later cycle in which `dbb_i` is low both in that cycle and in the cycle before.
- R9: `dbg_o` is never high while `dbb_i` is high, and it gives one single-cycle pulse per transfer start.
- R10: An arbitration point is any cycle with no held tenure, or any cycle with `ts_i` high. The decision made there shows on `gnt_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Bus request, one bit per master |
| ts_i | input | 1 | Transfer start from the granted master |
| dbb_i | input | 1 | Data bus busy |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Write target: slots 0–7, slots 8–15, mode |
| wr_data_i | input | 32 | Write data |
| gnt_o | output | 16 | One-hot address grant |
| dbg_o | output | 1 | Data bus grant |

## Verification
The data-grant properties assume a new transfer start never arrives while an earlier data grant is still outstanding. The random stimulus therefore raises `ts_i` only when its own model has no data grant pending. Requests, busy, table and mode writes (including unused select codes and set reserved bits) are drawn freely. Transfer starts may come both during a held tenure and while the bus is parked.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // Width of one configuration write word
    localparam int REG_W        = 32;
    // Position of the data-grant delay flag inside the mode word
    localparam int MODE_DLY_BIT = 5;
endpackage

// File: rtl/prio_table.sv
module prio_table
    import arb_pkg::*;
#(
    parameter int N        = 16,
    parameter int IDX_W    = 4,
    parameter int SEL_W    = 2,
    parameter int PARK_RST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output logic [N*IDX_W-1:0]   tbl_o,
    output logic [IDX_W-1:0]     park_o,
    output logic                 dly_o
);
    localparam int SPW      = REG_W / IDX_W;   // slots per write word
    localparam int NW       = N / SPW;         // words holding the table
    localparam int MODE_SEL = NW;              // select code of the mode word

    typedef struct packed {
        logic [N*IDX_W-1:0] tbl;
        logic [IDX_W-1:0]   park;
        logic               dly;
    } cfg_t;

    function automatic logic [N*IDX_W-1:0] ident_tbl();
        logic [N*IDX_W-1:0] t;
        t = '0;
        for (int s = 0; s < N; s++) begin
            t[s*IDX_W +: IDX_W] = IDX_W'(s);
        end
        return t;
    endfunction

    localparam logic [N*IDX_W-1:0] TBL_RST = ident_tbl();

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            if (int'(wr_sel_i) < NW) begin
                for (int k = 0; k < SPW; k++) begin
                    cfg_d.tbl[(int'(wr_sel_i)*SPW + k)*IDX_W +: IDX_W] =
                        wr_data_i[REG_W-1-k*IDX_W -: IDX_W];
                end
            end else if (int'(wr_sel_i) == MODE_SEL) begin
                cfg_d.dly  = wr_data_i[MODE_DLY_BIT];
                cfg_d.park = wr_data_i[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tbl  <= TBL_RST;
            cfg_q.park <= IDX_W'(PARK_RST);
            cfg_q.dly  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tbl_o  = cfg_q.tbl;
    assign park_o = cfg_q.park;
    assign dly_o  = cfg_q.dly;
endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]       req_i,
    input  logic [N*IDX_W-1:0] tbl_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   win_o
);
    localparam int SPACE = 2**IDX_W;

    logic [IDX_W-1:0] slot_idx [N];
    logic [SPACE-1:0] req_x;

    for (genvar s = 0; s < N; s++) begin : g_slot
        assign slot_idx[s] = tbl_i[s*IDX_W +: IDX_W];
    end

    always_comb begin
        req_x        = '0;
        req_x[N-1:0] = req_i;
    end

    // Walk from the weakest slot up so the strongest hit is written last
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int s = N-1; s >= 0; s--) begin
            if (req_x[slot_idx[s]]) begin
                hit_o = 1'b1;
                win_o = slot_idx[s];
            end
        end
    end
endmodule

// File: rtl/addr_grant_ctrl.sv
module addr_grant_ctrl #(
    parameter int N        = 16,
    parameter int IDX_W    = 4,
    parameter int PARK_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] win_i,
    input  logic [IDX_W-1:0] park_i,
    output logic [N-1:0]     gnt_o,
    output logic             locked_o,
    output logic             arb_o
);
    typedef struct packed {
        logic [N-1:0] gnt;
        logic         locked;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d  = ag_q;
        arb_o = !ag_q.locked || ts_i;
        if (arb_o) begin
            if (hit_i) begin
                ag_d.gnt    = N'(1) << win_i;
                ag_d.locked = 1'b1;
            end else begin
                ag_d.gnt    = N'(1) << park_i;
                ag_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ag_q.gnt    <= N'(1) << PARK_RST;
            ag_q.locked <= 1'b0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign gnt_o    = ag_q.gnt;
    assign locked_o = ag_q.locked;
endmodule

// File: rtl/data_grant_ctrl.sv
module data_grant_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_i,
    input  logic dbb_i,
    input  logic dly_i,
    output logic dbg_o
);
    typedef struct packed {
        logic pend;    // a transfer start is waiting for its data grant
        logic armed;   // bus was free in the previous pending cycle
    } dg_t;

    dg_t dg_d, dg_q;

    always_comb begin
        if (dly_i) begin
            dbg_o = dg_q.pend && dg_q.armed && !dbb_i;
        end else begin
            dbg_o = (ts_i || dg_q.pend) && !dbb_i;
        end

        dg_d = dg_q;
        if (dbg_o) begin
            dg_d.pend  = 1'b0;
            dg_d.armed = 1'b0;
        end else if (ts_i) begin
            dg_d.pend  = 1'b1;
            dg_d.armed = !dbb_i;
        end else if (dg_q.pend) begin
            dg_d.armed = !dbb_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dg_q <= '0;
        end else begin
            dg_q <= dg_d;
        end
    end
endmodule

// File: rtl/prio_park_arbiter.sv
module prio_park_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 16,
    parameter int IDX_W     = $clog2(N_MASTERS),
    parameter int PARK_RST  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 ts_i,
    input  logic                 dbb_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic                 dbg_o
);
    logic [N_MASTERS*IDX_W-1:0] tbl_w;
    logic [IDX_W-1:0]           park_w;
    logic                       dly_w;
    logic                       hit_w;
    logic [IDX_W-1:0]           win_w;
    logic                       locked_w;
    logic                       arb_w;

    prio_table #(
        .N(N_MASTERS), .IDX_W(IDX_W), .SEL_W(2), .PARK_RST(PARK_RST)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .tbl_o(tbl_w), .park_o(park_w), .dly_o(dly_w)
    );

    prio_select #(
        .N(N_MASTERS), .IDX_W(IDX_W)
    ) u_select (
        .req_i(req_i), .tbl_i(tbl_w), .hit_o(hit_w), .win_o(win_w)
    );

    addr_grant_ctrl #(
        .N(N_MASTERS), .IDX_W(IDX_W), .PARK_RST(PARK_RST)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .ts_i(ts_i),
        .hit_i(hit_w), .win_i(win_w), .park_i(park_w),
        .gnt_o(gnt_o), .locked_o(locked_w), .arb_o(arb_w)
    );

    data_grant_ctrl u_data (
        .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .dbb_i(dbb_i),
        .dly_i(dly_w), .dbg_o(dbg_o)
    );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             ts,
    input logic             dbb,
    input logic [N-1:0]     gnt,
    input logic             dbg,
    input logic             locked,
    input logic             arb,
    input logic             hit,
    input logic [IDX_W-1:0] park,
    input logic             dly
);
    logic [N-1:0] park_oh;
    assign park_oh = N'(1) << park;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(gnt)); // R6
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !ts) |=> $stable(gnt)); // R5
    AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb && !hit) |=> (gnt == $past(park_oh))); // R4
    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (arb && hit) |=> |(gnt & $past(req))); // R2
    AST_DBG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg |-> !dbb); // R9
    AST_DBG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg |=> (!dbg || ts)); // R9
    AST_DBG_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly && ts && !dbb) |-> dbg); // R7
    AST_DBG_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dly && ts) |-> !dbg); // R8
endmodule

bind prio_park_arbiter arb_checker #(.N(N_MASTERS), .IDX_W(IDX_W)) u_arb_checker (
    .clk(clk), .rst_n(rst_n), .req(req_i), .ts(ts_i), .dbb(dbb_i),
    .gnt(gnt_o), .dbg(dbg_o), .locked(locked_w), .arb(arb_w),
    .hit(hit_w), .park(park_w), .dly(dly_w)
);

// File: tb/test_prio_park_arbiter.sv
`timescale 1ns/1ps
module test_prio_park_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        ts_i = 1'b0;
    logic        dbb_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [15:0] gnt_o;
    logic        dbg_o;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state built from the requirements
    int          m_tbl [16];
    int          m_park;
    bit          m_dly;
    logic [15:0] m_gnt;
    bit          m_locked;
    bit          m_pend;
    bit          m_armed;
    string       m_gtag;

    always #2.5 clk = ~clk;

    prio_park_arbiter i_prio_park_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ts_i(ts_i), .dbb_i(dbb_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .gnt_o(gnt_o), .dbg_o(dbg_o)
    );

    function automatic int pick(logic [15:0] r);
        for (int s = 0; s < 16; s++) begin
            if (r[m_tbl[s]]) return m_tbl[s];
        end
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(logic [15:0] r, bit t, bit d, bit w, logic [1:0] s,
                         logic [31:0] wd, string ghint, string dhint);
        bit edbg;
        int win;
        @(negedge clk);
        req_i = r; ts_i = t; dbb_i = d; wr_en_i = w; wr_sel_i = s; wr_data_i = wd;
        #1;
        if (m_dly) edbg = m_pend && m_armed && !d;
        else       edbg = (t || m_pend) && !d;
        check((ghint != "") ? ghint : m_gtag, 32'(gnt_o), 32'(m_gnt));
        check("R6", 32'($countones(gnt_o)), 32'd1);
        check((dhint != "") ? dhint : (m_dly ? "R8" : "R7"), 32'(dbg_o), 32'(edbg));
        @(posedge clk);
        // address grant (R10: decision appears next cycle)
        if (!m_locked || t) begin
            win = pick(r);
            if (win >= 0) begin
                m_gnt = 16'(1) << win; m_locked = 1'b1; m_gtag = "R2";
            end else begin
                m_gnt = 16'(1) << m_park; m_locked = 1'b0; m_gtag = "R4";
            end
        end else begin
            m_gtag = "R5";
        end
        // data grant
        if (edbg) begin
            m_pend = 1'b0; m_armed = 1'b0;
        end else if (t) begin
            m_pend = 1'b1; m_armed = !d;
        end else if (m_pend) begin
            m_armed = !d;
        end
        // configuration write (R3)
        if (w) begin
            if (s < 2) begin
                for (int k = 0; k < 8; k++) m_tbl[s*8 + k] = int'(wd[31-4*k -: 4]);
            end else if (s == 2) begin
                m_dly  = wd[5];
                m_park = int'(wd[3:0]);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 16; s++) m_tbl[s] = s;
        m_park = 2; m_dly = 1'b0; m_gnt = 16'h0004; m_locked = 1'b0;
        m_pend = 1'b0; m_armed = 1'b0; m_gtag = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state parks on master 2
        cycle(16'h0000, 0, 0, 0, 0, 0, "R1", "R1");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R1", "R1");
        // R10: request seen now, grant changes next cycle
        cycle(16'h0006, 0, 0, 0, 0, 0, "R10", "");
        // R2: master 1 beats master 2 under default table
        cycle(16'h0006, 0, 0, 0, 0, 0, "R2", "");
        // R7: fast data grant with transfer start, re-arbitrate to master 2
        cycle(16'h0004, 1, 0, 0, 0, 0, "R5", "R7");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R2", "R9");
        // R5: table write while tenure is held does not move the grant
        cycle(16'h0000, 0, 0, 1, 0, 32'h5512_3467, "R5", "");
        // R7: start while busy holds the data grant off
        cycle(16'h0000, 1, 1, 0, 0, 0, "R5", "R7");
        cycle(16'h0000, 0, 1, 0, 0, 0, "R4", "R9");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R4", "R7");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R4", "R9");
        // R2/R3: master 5 now in slot 0 and slot 1, beats master 0
        cycle(16'h0021, 0, 0, 0, 0, 0, "R4", "");
        // R3: mode write with reserved bits set: delay on, park 9
        cycle(16'h0000, 0, 0, 1, 2, 32'h0000_00F9, "R3", "");
        // R8: delayed data grant
        cycle(16'h0000, 1, 0, 0, 0, 0, "R5", "R8");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R3", "R8");
        cycle(16'h0000, 1, 1, 0, 0, 0, "R4", "R8");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R4", "R8");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R4", "R8");
        // R3: select code 3 is ignored
        cycle(16'h0000, 0, 0, 1, 3, 32'h0000_0000, "R3", "R9");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R3", "R9");
        // R3: second table half, master 15 into slot 8 (still below slot 0..7)
        cycle(16'h0000, 0, 0, 1, 1, 32'hF000_0000, "R4", "");
        cycle(16'h8000, 0, 0, 0, 0, 0, "R4", "");
        cycle(16'h0000, 0, 0, 0, 0, 0, "R3", "");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] r;
            bit t, d, w;
            logic [1:0] s;
            r = ($urandom_range(0, 3) == 0) ? 16'h0 : (16'($urandom) & 16'($urandom));
            t = !m_pend && ($urandom_range(0, 3) == 0);
            d = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 40) == 0);
            s = 2'($urandom_range(0, 3));
            cycle(r, t, d, w, s, $urandom, "", "");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule